// File: doc/BRIEF.md
# Packed Byte Add/Subtract Unit

This is a combinational execution unit for a scalar core that supports packed byte arithmetic. It takes one 32-bit R-type instruction word and two register operands of XLEN bits. When the instruction names one of ten byte-wise add or subtract operations, the unit splits each operand into XLEN/8 independent 8-bit lanes and produces the result word.

Each operation combines a direction (add or subtract) with one of five lane behaviours:

- wrap modulo 256;
- signed halving;
- unsigned halving;
- signed saturation;
- unsigned saturation.

Any lane that clamps during a saturating operation raises a one-cycle overflow-set output. The surrounding pipeline uses that output to update its sticky overflow flag.

The register file, pipeline staging and the flag register are not part of this block. The unit has no clock. The result is a pure function of the current inputs.

Top module: `simd8_addsub`

## Requirements
- R1: `valid` is 1 only when all three hold: `instr[6:0]` is 1111111, `instr[14:12]` is 000, and `instr[31:25]` is one of the ten encodings listed below. In every other case `valid` is 0, `result` is zero and `ovf_set` is 0.
- R2: funct7 0100100 gives each lane (a+b) mod 256. No carry crosses from one lane into the next.
- R3: funct7 0100101 gives each lane (a-b) mod 256. No borrow crosses from one lane into the next.
- R4: funct7 0000100 and 0000101 treat each lane as signed. The lane result is floor((a+b)/2) or floor((a-b)/2), computed in 9 bits with no rounding increment.
- R5: funct7 0010100 and 0010101 treat each lane as unsigned. The lane result is bits [8:1] of the 9-bit sum or difference. For example, 0 minus 1 gives 0xFF.
- R6: funct7 0001100 and 0001101 clamp each signed lane sum or difference to the range -128..127.
- R7: funct7 0011100 clamps each unsigned lane sum at 255. funct7 0011101 clamps each unsigned lane difference at 0.
- R8: `ovf_set` is 1 exactly when a saturating operation (R6 or R7) clamps at least one lane. It is 0 for all wrap and halving operations.
- R9: Lane i occupies bits [8i+7:8i] of `rs1_val`, `rs2_val` and `result`. The rd, rs1 and rs2 fields of `instr` (bits [24:15] and [11:7]) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | R-type instruction word |
| rs1_val | input | XLEN | First operand (a) |
| rs2_val | input | XLEN | Second operand (b) |
| result | output | XLEN | Packed lane result, zero when not decoded |
| valid | output | 1 | Instruction decoded as one of the ten operations |
| ovf_set | output | 1 | Pulse telling the pipeline to set the sticky overflow flag |

## Verification
A saturating operation can clamp some lanes and leave others exact within the same word. In that case the clamp detection and the per-lane value selection both act on a single result. The bench provokes this with operand words that mix boundary bytes (0x7F, 0x80, 0xFF, 0x00) with small values, and with random operands. It then checks every lane against a per-lane model. It also checks that `ovf_set` matches the OR of the modelled clamps, so that a word with only one clamped lane must still raise the pulse.

// File: rtl/simd8_pkg.sv
package simd8_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_WRAP,
        K_HALF_S,
        K_HALF_U,
        K_SAT_S,
        K_SAT_U
    } kind_e;

    typedef struct packed {
        logic  valid;
        logic  sub;
        kind_e kind;
    } op_t;

    localparam logic [6:0] OPC_PACKED = 7'b1111111;
    localparam logic [2:0] F3_BYTE    = 3'b000;

    // funct7[0] selects subtract; funct7[6:1] selects the flavour
    localparam logic [5:0] F7H_WRAP   = 6'b010010;
    localparam logic [5:0] F7H_HALF_S = 6'b000010;
    localparam logic [5:0] F7H_HALF_U = 6'b001010;
    localparam logic [5:0] F7H_SAT_S  = 6'b000110;
    localparam logic [5:0] F7H_SAT_U  = 6'b001110;

    function automatic logic [8:0] ext_s(input logic [7:0] x);
        return {x[7], x};
    endfunction

    function automatic logic [8:0] ext_u(input logic [7:0] x);
        return {1'b0, x};
    endfunction

endpackage

// File: rtl/simd8_decode.sv
module simd8_decode
    import simd8_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output op_t        op
);
    kind_e kind_d;

    always_comb begin
        case (funct7[6:1])
            F7H_WRAP:   kind_d = K_WRAP;
            F7H_HALF_S: kind_d = K_HALF_S;
            F7H_HALF_U: kind_d = K_HALF_U;
            F7H_SAT_S:  kind_d = K_SAT_S;
            F7H_SAT_U:  kind_d = K_SAT_U;
            default:    kind_d = K_NONE;
        endcase
    end

    always_comb begin
        op.valid = (opcode == OPC_PACKED) && (funct3 == F3_BYTE) && (kind_d != K_NONE);
        op.sub   = funct7[0];
        op.kind  = op.valid ? kind_d : K_NONE;
    end
endmodule

// File: rtl/simd8_wrap.sv
module simd8_wrap #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] res
);
    localparam int LANES = XLEN / 8;
    localparam logic [XLEN-1:0] MSB_MASK = {LANES{8'h80}};

    logic [XLEN-1:0] sum_w, dif_w;

    // Lane MSBs are cleared (or forced for subtract) so that carries and borrows
    // stop at each lane top; the true MSB is then restored by the XOR term.
    always_comb begin
        sum_w = ((a & ~MSB_MASK) + (b & ~MSB_MASK)) ^ ((a ^ b) & MSB_MASK);
        dif_w = ((a | MSB_MASK) - (b & ~MSB_MASK)) ^ (~(a ^ b) & MSB_MASK);
        res   = sub ? dif_w : sum_w;
    end
endmodule

// File: rtl/simd8_lane.sv
module simd8_lane
    import simd8_pkg::*;
(
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic       sub,
    input  kind_e      kind,
    output logic [7:0] res,
    output logic       clamp
);
    logic [8:0] s9, u9;
    logic       s_ovf, u_ovf;

    always_comb begin
        s9    = sub ? (ext_s(a) - ext_s(b)) : (ext_s(a) + ext_s(b));
        u9    = sub ? (ext_u(a) - ext_u(b)) : (ext_u(a) + ext_u(b));
        s_ovf = s9[8] ^ s9[7];
        u_ovf = u9[8];
        res   = 8'h00;
        clamp = 1'b0;
        case (kind)
            K_HALF_S, K_HALF_U: res = (kind == K_HALF_S) ? s9[8:1] : u9[8:1];
            K_SAT_S: begin
                clamp = s_ovf;
                res   = s_ovf ? (s9[8] ? 8'h80 : 8'h7F) : s9[7:0];
            end
            K_SAT_U: begin
                clamp = u_ovf;
                res   = u_ovf ? (sub ? 8'h00 : 8'hFF) : u9[7:0];
            end
            default: res = 8'h00;
        endcase
    end
endmodule

// File: rtl/simd8_addsub.sv
module simd8_addsub
    import simd8_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [XLEN-1:0] result,
    output logic            valid,
    output logic            ovf_set
);
    localparam int LANES = XLEN / 8;

    op_t             op;
    logic [XLEN-1:0] wrap_res;
    logic [XLEN-1:0] lane_res;
    logic [LANES-1:0] lane_clamp;
    logic            unused_fields;

    assign unused_fields = ^{instr[24:15], instr[11:7]};

    simd8_decode u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .op     (op)
    );

    simd8_wrap #(.XLEN(XLEN)) u_wrap (
        .a   (rs1_val),
        .b   (rs2_val),
        .sub (op.sub),
        .res (wrap_res)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd8_lane u_lane (
            .a     (rs1_val[8*i +: 8]),
            .b     (rs2_val[8*i +: 8]),
            .sub   (op.sub),
            .kind  (op.kind),
            .res   (lane_res[8*i +: 8]),
            .clamp (lane_clamp[i])
        );
    end

    always_comb begin
        if (!op.valid)               result = '0;
        else if (op.kind == K_WRAP)  result = wrap_res;
        else                         result = lane_res;
        valid   = op.valid;
        ovf_set = op.valid && ((op.kind == K_SAT_S) || (op.kind == K_SAT_U)) && (|lane_clamp);
    end
endmodule

// File: rtl/simd8_addsub_chk.sv
module simd8_addsub_chk #(
    parameter int XLEN = 64
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [XLEN-1:0] result,
    input logic            valid,
    input logic            ovf_set
);
    localparam int LANES = XLEN / 8;

    always_comb begin
        // R1: nothing leaves the unit unless the word decoded
        p_idle_zero_r1: assert (valid || (result == '0 && !ovf_set));
        p_gate_r1: assert (!valid || (instr[6:0] == 7'h7F && instr[14:12] == 3'b000));
        // R8: the flag pulse only comes from saturating encodings
        p_ovf_kind_r8: assert (!ovf_set || (valid && instr[28] && !instr[30]));
        for (int i = 0; i < LANES; i++) begin
            // R2/R3: wrap lanes equal the 8-bit modular sum or difference
            p_wrap_r2: assert (!(valid && instr[31:26] == 6'b010010) ||
                result[8*i +: 8] == (instr[25] ? rs1_val[8*i +: 8] - rs2_val[8*i +: 8]
                                               : rs1_val[8*i +: 8] + rs2_val[8*i +: 8]));
            // R6/R7: a saturating op with no overflow equals the modular result
            p_no_overflow_r6: assert (!(valid && instr[28] && !ovf_set) ||
                result[8*i +: 8] == (instr[25] ? rs1_val[8*i +: 8] - rs2_val[8*i +: 8]
                                               : rs1_val[8*i +: 8] + rs2_val[8*i +: 8]));
        end
    end
endmodule

bind simd8_addsub simd8_addsub_chk #(.XLEN(XLEN)) u_chk (
    .instr   (instr),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .result  (result),
    .valid   (valid),
    .ovf_set (ovf_set)
);

// File: tb/simd8_addsub_test.sv
module simd8_addsub_test;
    localparam int XLEN  = 64;
    localparam int LANES = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic [XLEN-1:0] rs2_val = '0;
    logic [XLEN-1:0] result;
    logic            valid;
    logic            ovf_set;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    simd8_addsub #(.XLEN(XLEN)) uut (
        .instr   (instr),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .result  (result),
        .valid   (valid),
        .ovf_set (ovf_set)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] opc, input logic [14:0] regs);
        return {f7, regs[14:5], f3, regs[4:0], opc};
    endfunction

    function automatic string tag(input logic [6:0] f7);
        case (f7)
            7'b0100100: return "R2";
            7'b0100101: return "R3";
            7'b0000100, 7'b0000101: return "R4";
            7'b0010100, 7'b0010101: return "R5";
            7'b0001100, 7'b0001101: return "R6";
            7'b0011100, 7'b0011101: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic model(input logic [31:0] ins, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         output logic [XLEN-1:0] r, output logic v, output logic o);
        logic [6:0] f7 = ins[31:25];
        r = '0; o = 1'b0;
        v = (ins[6:0] == 7'h7F) && (ins[14:12] == 3'b000) && (tag(f7) != "R1");
        if (!v) return;
        for (int i = 0; i < LANES; i++) begin
            int sa = int'($signed(a[8*i +: 8]));
            int sb = int'($signed(b[8*i +: 8]));
            int ua = int'(a[8*i +: 8]);
            int ub = int'(b[8*i +: 8]);
            int t  = 0;
            case (f7)
                7'b0100100: t = ua + ub;
                7'b0100101: t = ua - ub;
                7'b0000100: t = (sa + sb) >>> 1;
                7'b0000101: t = (sa - sb) >>> 1;
                7'b0010100: t = (ua + ub) >>> 1;
                7'b0010101: t = (ua - ub) >>> 1;
                7'b0001100, 7'b0001101: begin
                    t = f7[0] ? sa - sb : sa + sb;
                    if (t > 127)  begin t = 127;  o = 1'b1; end
                    if (t < -128) begin t = -128; o = 1'b1; end
                end
                default: begin
                    t = f7[0] ? ua - ub : ua + ub;
                    if (t > 255) begin t = 255; o = 1'b1; end
                    if (t < 0)   begin t = 0;   o = 1'b1; end
                end
            endcase
            r[8*i +: 8] = t[7:0];
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input string req);
        logic [XLEN-1:0] er;
        logic ev, eo;
        @(posedge clk);
        instr = ins; rs1_val = a; rs2_val = b;
        model(ins, a, b, er, ev, eo);
        @(negedge clk);
        checks++;
        if (result !== er || valid !== ev || ovf_set !== eo) begin
            errors++;
            $display("FAIL %s instr=%h a=%h b=%h actual r=%h v=%b o=%b expected r=%h v=%b o=%b",
                     req, ins, a, b, result, valid, ovf_set, er, ev, eo);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [6:0] ops [10] = '{7'b0100100, 7'b0000100, 7'b0010100, 7'b0001100, 7'b0011100,
                                 7'b0100101, 7'b0000101, 7'b0010101, 7'b0001101, 7'b0011101};
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1: reset-state and illegal words
        run(32'h0, 64'h0102030405060708, 64'h1111111111111111, "R1");
        run(mk(7'b0100100, 3'b000, 7'h33, 15'h0), {8{8'h7F}}, {8{8'h01}}, "R1");
        run(mk(7'b0001100, 3'b001, 7'h7F, 15'h0), {8{8'h7F}}, {8{8'h01}}, "R1");
        run(mk(7'b0100110, 3'b000, 7'h7F, 15'h0), {8{8'h7F}}, {8{8'h01}}, "R1");
        // R2/R3: carries and borrows stay inside their lanes
        run(mk(7'b0100100, 3'b000, 7'h7F, 15'h0), {8{8'hFF}}, {8{8'h01}}, "R2");
        run(mk(7'b0100101, 3'b000, 7'h7F, 15'h0), {8{8'h00}}, {8{8'h01}}, "R3");
        // R4/R5: halving floors, no rounding
        run(mk(7'b0000100, 3'b000, 7'h7F, 15'h0), {8{8'h81}}, {8{8'h80}}, "R4");
        run(mk(7'b0000101, 3'b000, 7'h7F, 15'h0), 64'h7F80_0001_7F80_0100, 64'h8001_0100_807F_0001, "R4");
        run(mk(7'b0010101, 3'b000, 7'h7F, 15'h0), {8{8'h00}}, {8{8'h01}}, "R5");
        run(mk(7'b0010100, 3'b000, 7'h7F, 15'h0), {8{8'hFF}}, {8{8'hFF}}, "R5");
        // R6/R7/R8: mixed clamped and exact lanes in one word
        run(mk(7'b0001100, 3'b000, 7'h7F, 15'h0), 64'h7F05_7F05_8005_0102, 64'h0101_0001_FF01_0203, "R6");
        run(mk(7'b0001101, 3'b000, 7'h7F, 15'h0), 64'h8000_0000_0000_0000, 64'h0100_0000_0000_0000, "R6");
        run(mk(7'b0011100, 3'b000, 7'h7F, 15'h0), 64'hFF00_0000_0000_0010, 64'h0100_0000_0000_0020, "R7");
        run(mk(7'b0011101, 3'b000, 7'h7F, 15'h0), 64'h0000_0000_0000_0030, 64'h0100_0000_0000_0010, "R7");
        run(mk(7'b0001100, 3'b000, 7'h7F, 15'h0), 64'h1020_3040_5060_7001, 64'h0101_0101_0101_0101, "R8");
        run(mk(7'b0000100, 3'b000, 7'h7F, 15'h0), {8{8'h7F}}, {8{8'h7F}}, "R8");
        // R9: register fields are randomised and lanes checked by position
        for (int n = 0; n < 2000; n++) begin
            logic [6:0] f7 = ops[$urandom_range(0, 9)];
            logic [XLEN-1:0] a = {$urandom(), $urandom()};
            logic [XLEN-1:0] b = {$urandom(), $urandom()};
            logic [14:0] regs = 15'($urandom());
            if (n % 4 == 0) b = ~a;
            run(mk(f7, 3'b000, 7'h7F, regs), a, b, (n % 2 == 0) ? "R9" : tag(f7));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule